// File: doc/BRIEF.md
# Retriggered Multiscan Acquisition Sequencer

This block sets the order and timing of conversions for a multichannel data-acquisition front end. The block holds no channel-gain list of its own. It produces a strobe for each conversion and the list position that the conversion should use. The ADC path looks up channel and gain from that position. Conversions advance one list entry per sample-clock tick. Once the position passes the last entry, it wraps to zero and the scan count goes up by one.

A start pulse arms the first burst. One burst covers the whole list a programmed number of times. After a burst, a programmable settle interval runs. The block then waits for a retrigger. The retrigger comes either from an internal periodic timer, which starts at the start pulse, or from an external pulse input. A retrigger that arrives during a burst or during the settle interval is dropped and sets a sticky overrun flag. A trigger-status output is high whenever the block is not converting. A stop command or a buffer-full input returns the block to idle.

Top module: `mscan_seq`

## Requirements
- R1: After reset, `trig_out` is 1, `conv_stb` is 0, `conv_idx` is 0 and `ovr_flag` is 0.
- R2: In idle, `sample_tick`, `ext_retrig` and the internal timer have no effect. No strobe appears and the overrun flag is not set. A `start` that arrives while a burst, settle or armed phase is active is ignored.
- R3: While acquiring, a `sample_tick` high in cycle n gives `conv_stb` = 1 in cycle n+1. No other cycle carries a strobe.
- R4: The `conv_idx` that goes with each strobe runs 0, 1, …, `cfg_len`−1 and then wraps to 0. A burst is exactly `cfg_len` × `cfg_scans` strobes. `conv_idx` keeps its last value between strobes.
- R5: `trig_out` is 0 exactly while a burst is in progress and 1 in idle, settle and armed.
- R6: After the last strobe of a burst, the block stays in settle for `cfg_settle` cycles before it is armed. A value of 0 arms it at once.
- R7: With `cfg_ext_mode` = 1, an `ext_retrig` pulse while armed starts a new burst in the next cycle, and the internal timer is ignored.
- R8: With `cfg_ext_mode` = 0, a retrigger fires every `cfg_period` cycles. The count begins with the first cycle after the accepted start, and `ext_retrig` is ignored.
- R9: A retrigger from the selected source during a burst or during settle is dropped and sets `ovr_flag`. The flag stays set.
- R10: `ovr_clr` clears `ovr_flag`. A new overrun in the same cycle takes priority.
- R11: `stop` or `buf_full` sends the block to idle at the next edge, with no further strobes. This takes priority over `start`.
- R12: A 1024-entry list and a scan count of 256 are both supported at their full size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | 11 | List length, 1 to 1024 |
| cfg_scans | input | 9 | Scans per burst, 1 to 256 |
| cfg_ext_mode | input | 1 | 1 selects the external retrigger, 0 the internal timer |
| cfg_period | input | 24 | Internal retrigger period in clock cycles, at least 1 |
| cfg_settle | input | 8 | Settle cycles between the end of a burst and re-arming |
| start | input | 1 | Initial trigger pulse |
| stop | input | 1 | Stop command |
| buf_full | input | 1 | Buffer-full indication, acts like stop |
| sample_tick | input | 1 | One-cycle pulse per sample-clock tick |
| ext_retrig | input | 1 | External retrigger pulse (digital edge or threshold crossing) |
| ovr_clr | input | 1 | Clears the overrun flag |
| conv_stb | output | 1 | Conversion strobe |
| conv_idx | output | 10 | List position of the conversion |
| trig_out | output | 1 | High while waiting, low while acquiring |
| ovr_flag | output | 1 | Sticky retrigger overrun flag |

## Verification
The assertions assume the configuration inputs stay constant from the accepted start until the block is back in idle. They also assume `cfg_len` lies in 1 to 1024, `cfg_scans` in 1 to 256 and `cfg_period` is at least 1. The bound on `conv_idx` and the timer wrap both depend on these ranges. The bench keeps to these limits by issuing a stop, or by waiting in idle, before it writes any configuration field. Every value it programs falls inside the stated ranges.

// File: rtl/mscan_pkg.sv
package mscan_pkg;

    localparam int unsigned LIST_MAX_DEF = 1024;
    localparam int unsigned SCAN_MAX_DEF = 256;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_ACQ    = 2'd1,
        SEQ_SETTLE = 2'd2,
        SEQ_ARMED  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic halt;   // stop or buffer full
        logic go;     // initial trigger
        logic rtrig;  // retrigger from the selected source
    } seq_evt_t;

    // true when a zero-based position is the last of lim entries
    function automatic logic at_limit(input int unsigned pos, input int unsigned lim);
        return (pos + 1) == lim;
    endfunction

endpackage

// File: rtl/mscan_rtrig.sv
module mscan_rtrig #(
    parameter int unsigned PER_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             ext_mode,
    input  logic [PER_W-1:0] period,
    input  logic             ext_evt,
    output logic             fire
);

    logic [PER_W-1:0] tmr_q;
    logic             wrap;

    always_comb begin
        wrap = run && (tmr_q == (period - PER_W'(1)));
        fire = ext_mode ? ext_evt : wrap;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tmr_q <= '0;
        end else if (wrap) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + PER_W'(1);
        end
    end

endmodule

// File: rtl/mscan_walk.sv
module mscan_walk #(
    parameter int unsigned LIST_MAX = mscan_pkg::LIST_MAX_DEF,
    parameter int unsigned SCAN_MAX = mscan_pkg::SCAN_MAX_DEF,
    localparam int unsigned IDX_W  = $clog2(LIST_MAX),
    localparam int unsigned LEN_W  = $clog2(LIST_MAX + 1),
    localparam int unsigned SC_W   = $clog2(SCAN_MAX),
    localparam int unsigned SCFG_W = $clog2(SCAN_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              step,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [SCFG_W-1:0] cfg_scans,
    output logic [IDX_W-1:0]  idx,
    output logic              burst_end
);

    logic [IDX_W-1:0] idx_q;
    logic [SC_W-1:0]  scan_q;
    logic             row_end;
    logic             scan_end;

    always_comb begin
        row_end   = mscan_pkg::at_limit(32'(idx_q), 32'(cfg_len));
        scan_end  = mscan_pkg::at_limit(32'(scan_q), 32'(cfg_scans));
        burst_end = step && row_end && scan_end;
        idx       = idx_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx_q  <= '0;
            scan_q <= '0;
        end else if (step) begin
            if (row_end) begin
                idx_q  <= '0;
                scan_q <= scan_end ? '0 : scan_q + SC_W'(1);
            end else begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/mscan_settle.sv
module mscan_settle #(
    parameter int unsigned SET_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SET_W-1:0] span,
    output logic             last
);

    logic [SET_W-1:0] left_q;

    assign last = (left_q == SET_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= span;
        end else if (left_q != '0) begin
            left_q <= left_q - SET_W'(1);
        end
    end

endmodule

// File: rtl/mscan_seq.sv
module mscan_seq #(
    parameter int unsigned LIST_MAX = mscan_pkg::LIST_MAX_DEF,
    parameter int unsigned SCAN_MAX = mscan_pkg::SCAN_MAX_DEF,
    parameter int unsigned PER_W    = 24,
    parameter int unsigned SET_W    = 8,
    localparam int unsigned IDX_W  = $clog2(LIST_MAX),
    localparam int unsigned LEN_W  = $clog2(LIST_MAX + 1),
    localparam int unsigned SCFG_W = $clog2(SCAN_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [SCFG_W-1:0] cfg_scans,
    input  logic              cfg_ext_mode,
    input  logic [PER_W-1:0]  cfg_period,
    input  logic [SET_W-1:0]  cfg_settle,
    input  logic              start,
    input  logic              stop,
    input  logic              buf_full,
    input  logic              sample_tick,
    input  logic              ext_retrig,
    input  logic              ovr_clr,
    output logic              conv_stb,
    output logic [IDX_W-1:0]  conv_idx,
    output logic              trig_out,
    output logic              ovr_flag
);

    mscan_pkg::seq_state_e st_q, st_d;
    mscan_pkg::seq_evt_t   evt;

    logic             src_fire;
    logic             step;
    logic             walk_clr;
    logic             burst_end;
    logic             settle_last;
    logic             ovr_set;
    logic [IDX_W-1:0] pos;
    logic             stb_q;
    logic [IDX_W-1:0] idx_q;
    logic             ovr_q;

    mscan_rtrig #(.PER_W(PER_W)) u_rtrig (
        .clk      (clk),
        .rst      (rst),
        .run      (st_q != mscan_pkg::SEQ_IDLE),
        .ext_mode (cfg_ext_mode),
        .period   (cfg_period),
        .ext_evt  (ext_retrig),
        .fire     (src_fire)
    );

    mscan_walk #(.LIST_MAX(LIST_MAX), .SCAN_MAX(SCAN_MAX)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .clr       (walk_clr),
        .step      (step),
        .cfg_len   (cfg_len),
        .cfg_scans (cfg_scans),
        .idx       (pos),
        .burst_end (burst_end)
    );

    mscan_settle #(.SET_W(SET_W)) u_settle (
        .clk  (clk),
        .rst  (rst),
        .load (burst_end),
        .span (cfg_settle),
        .last (settle_last)
    );

    always_comb begin
        evt.halt  = stop || buf_full;
        evt.go    = start;
        evt.rtrig = src_fire;

        step     = (st_q == mscan_pkg::SEQ_ACQ) && sample_tick && !evt.halt;
        walk_clr = (st_q != mscan_pkg::SEQ_ACQ);
        ovr_set  = !evt.halt && evt.rtrig &&
                   ((st_q == mscan_pkg::SEQ_ACQ) || (st_q == mscan_pkg::SEQ_SETTLE));

        st_d = st_q;
        if (evt.halt) begin
            st_d = mscan_pkg::SEQ_IDLE;
        end else begin
            case (st_q)
                mscan_pkg::SEQ_IDLE: begin
                    if (evt.go) st_d = mscan_pkg::SEQ_ACQ;
                end
                mscan_pkg::SEQ_ACQ: begin
                    if (burst_end) begin
                        st_d = (cfg_settle == '0) ? mscan_pkg::SEQ_ARMED
                                                  : mscan_pkg::SEQ_SETTLE;
                    end
                end
                mscan_pkg::SEQ_SETTLE: begin
                    if (settle_last) st_d = mscan_pkg::SEQ_ARMED;
                end
                mscan_pkg::SEQ_ARMED: begin
                    if (evt.rtrig) st_d = mscan_pkg::SEQ_ACQ;
                end
                default: st_d = mscan_pkg::SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= mscan_pkg::SEQ_IDLE;
            stb_q <= 1'b0;
            idx_q <= '0;
            ovr_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            stb_q <= step;
            if (step) idx_q <= pos;
            if (ovr_set) begin
                ovr_q <= 1'b1;
            end else if (ovr_clr) begin
                ovr_q <= 1'b0;
            end
        end
    end

    assign conv_stb = stb_q;
    assign conv_idx = idx_q;
    assign trig_out = (st_q != mscan_pkg::SEQ_ACQ);
    assign ovr_flag = ovr_q;

endmodule

// File: rtl/mscan_seq_chk.sv
module mscan_seq_chk #(
    parameter int unsigned LEN_W = 11,
    parameter int unsigned IDX_W = 10
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic                  stop,
    input logic                  buf_full,
    input logic                  ovr_clr,
    input logic                  conv_stb,
    input logic [IDX_W-1:0]      conv_idx,
    input logic [LEN_W-1:0]      cfg_len,
    input logic                  trig_out,
    input logic                  ovr_flag,
    input mscan_pkg::seq_state_e st
);

    // R3
    stb_after_acq_chk: assert property (@(posedge clk) disable iff (rst)
        conv_stb |-> $past(st == mscan_pkg::SEQ_ACQ));

    // R4
    idx_in_list_chk: assert property (@(posedge clk) disable iff (rst)
        conv_stb |-> (LEN_W'(conv_idx) < cfg_len));

    // R11
    halt_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (stop || buf_full) |=> (trig_out && !conv_stb));

    // R10
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && !ovr_clr) |=> ovr_flag);

    // R9
    ovr_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_flag) |-> $past((st == mscan_pkg::SEQ_ACQ) || (st == mscan_pkg::SEQ_SETTLE)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((st == mscan_pkg::SEQ_IDLE) && !start) |=> (st == mscan_pkg::SEQ_IDLE));

endmodule

bind mscan_seq mscan_seq_chk #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .stop     (stop),
    .buf_full (buf_full),
    .ovr_clr  (ovr_clr),
    .conv_stb (conv_stb),
    .conv_idx (conv_idx),
    .cfg_len  (cfg_len),
    .trig_out (trig_out),
    .ovr_flag (ovr_flag),
    .st       (st_q)
);

// File: tb/mscan_seq_tb.sv
module mscan_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] cfg_len = 11'd4;
    logic [8:0]  cfg_scans = 9'd1;
    logic        cfg_ext = 1'b1;
    logic [23:0] cfg_period = 24'd50;
    logic [7:0]  cfg_settle = 8'd2;
    logic        start = 0, stop = 0, buf_full = 0, sample_tick = 0, ext_retrig = 0, ovr_clr = 0;
    logic        conv_stb, trig_out, ovr_flag;
    logic [9:0]  conv_idx;

    int checks = 0, fails = 0, stb_seen = 0, cyc_n = 0, tick_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    mscan_seq u_dut (
        .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_scans(cfg_scans),
        .cfg_ext_mode(cfg_ext), .cfg_period(cfg_period), .cfg_settle(cfg_settle),
        .start(start), .stop(stop), .buf_full(buf_full), .sample_tick(sample_tick),
        .ext_retrig(ext_retrig), .ovr_clr(ovr_clr), .conv_stb(conv_stb),
        .conv_idx(conv_idx), .trig_out(trig_out), .ovr_flag(ovr_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference: 0 idle, 1 acquiring, 2 settling, 3 armed
    int         m_st = 0, m_t = 0, m_done = 0, m_left = 0;
    logic       m_stb = 0, m_ovr = 0;
    logic [9:0] m_idx = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_t = 0; m_done = 0; m_left = 0;
            m_stb = 0; m_ovr = 0; m_idx = 0;
        end else begin
            bit halt, tfire, src, stb_n;
            int nst;
            halt  = stop || buf_full;
            tfire = (m_st != 0) && (m_t == int'(cfg_period) - 1);
            src   = cfg_ext ? ext_retrig : tfire;
            stb_n = (m_st == 1) && sample_tick && !halt;
            if (stb_n) begin
                m_idx = 10'(m_done % int'(cfg_len));
                m_done++;
            end
            m_stb = stb_n;
            if (!halt && src && (m_st == 1 || m_st == 2)) m_ovr = 1;
            else if (ovr_clr) m_ovr = 0;
            if (m_st == 0 || tfire) m_t = 0; else m_t++;
            nst = m_st;
            if (halt) nst = 0;
            else case (m_st)
                0: if (start) begin nst = 1; m_done = 0; end
                1: if (stb_n && m_done == int'(cfg_len) * int'(cfg_scans)) begin
                       if (cfg_settle == 0) nst = 3;
                       else begin nst = 2; m_left = int'(cfg_settle); end
                   end
                2: begin m_left--; if (m_left == 0) nst = 3; end
                default: if (src) begin nst = 1; m_done = 0; end
            endcase
            m_st = nst;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > WATCHDOG) begin
            checks++; fails++;
            $display("FAIL watchdog (all requirements): actual=%0d cycles expected<%0d", cyc_n, WATCHDOG);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare();
        chk(conv_stb === m_stb, "R3 conversion strobe", int'(conv_stb), int'(m_stb));
        chk(conv_idx === m_idx, "R4 list index", int'(conv_idx), int'(m_idx));
        chk(trig_out === (m_st != 1), "R5 trig_out level", int'(trig_out), int'(m_st != 1));
        chk(ovr_flag === m_ovr, "R9 overrun flag", int'(ovr_flag), int'(m_ovr));
        if (conv_stb === 1'b1) stb_seen++;
    endtask

    task automatic cyc(input bit s = 0, input bit e = 0, input bit sp = 0,
                       input bit bf = 0, input bit oc = 0);
        @(negedge clk);
        if (!rst) compare();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        start = s; ext_retrig = e; stop = sp; buf_full = bf; ovr_clr = oc;
        case (tick_mode)
            0: sample_tick = 1'b1;
            1: sample_tick = (cyc_n % 3 == 0);
            default: sample_tick = lfsr[0];
        endcase
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic wait_burst(input int maxn);
        for (int k = 0; k < maxn; k++) begin
            cyc();
            if (trig_out) break;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(trig_out === 1'b1, "R1 trig_out after reset", int'(trig_out), 1);
        chk(conv_stb === 1'b0, "R1 conv_stb after reset", int'(conv_stb), 0);
        chk(conv_idx === 10'd0, "R1 conv_idx after reset", int'(conv_idx), 0);
        chk(ovr_flag === 1'b0, "R1 ovr_flag after reset", int'(ovr_flag), 0);
        rst = 1'b0;

        // R2: ticks and retriggers before start do nothing
        cfg_ext = 1; cfg_len = 5; cfg_scans = 3; cfg_settle = 4; tick_mode = 0;
        stb_seen = 0;
        for (int k = 0; k < 20; k++) cyc(0, k % 4 == 0);
        chk(stb_seen == 0, "R2 no strobe before start", stb_seen, 0);
        chk(ovr_flag === 1'b0, "R2 no overrun before start", int'(ovr_flag), 0);

        // R4: one burst of 5 x 3
        stb_seen = 0;
        cyc(1);
        wait_burst(200);
        chk(stb_seen == 15, "R4 strobes per burst", stb_seen, 15);
        chk(conv_idx === 10'd4, "R4 last index of burst", int'(conv_idx), 4);
        // R9: retrigger during settle
        cyc(0, 1);
        cyc();
        chk(ovr_flag === 1'b1, "R9 overrun during settle", int'(ovr_flag), 1);
        // R10: clear
        cyc(0, 0, 0, 0, 1);
        cyc();
        chk(ovr_flag === 1'b0, "R10 overrun cleared", int'(ovr_flag), 0);
        // R7: external retrigger while armed
        idle(2);
        stb_seen = 0;
        cyc(0, 1);
        cyc();
        chk(trig_out === 1'b0, "R7 external retrigger starts burst", int'(trig_out), 0);
        idle(3);
        cyc(0, 1);  // R9 retrigger inside burst is dropped
        wait_burst(200);
        chk(stb_seen == 15, "R9 dropped retrigger leaves burst length", stb_seen, 15);
        chk(ovr_flag === 1'b1, "R9 overrun during burst", int'(ovr_flag), 1);

        // R8: internal timer, external pulses ignored
        cyc(0, 0, 1, 0, 1);
        cfg_ext = 0; cfg_len = 4; cfg_scans = 2; cfg_settle = 3; cfg_period = 40; tick_mode = 1;
        idle(2);
        stb_seen = 0;
        cyc(1);
        for (int k = 0; k < 200; k++) cyc(0, k % 7 == 0);
        chk(stb_seen >= 32, "R8 internal retriggers produce bursts", stb_seen, 32);
        chk(ovr_flag === 1'b0, "R8 no overrun with long period", int'(ovr_flag), 0);

        // R9/R10: short period overruns, clear held against new overruns
        cyc(0, 0, 1);
        cfg_period = 10;
        idle(2);
        cyc(1);
        idle(60);
        chk(ovr_flag === 1'b1, "R9 overrun with short period", int'(ovr_flag), 1);
        for (int k = 0; k < 30; k++) cyc(0, 0, 0, 0, 1);
        chk(ovr_flag === m_ovr, "R10 set wins over clear", int'(ovr_flag), int'(m_ovr));
        cyc(0, 0, 1);
        cyc(0, 0, 0, 0, 1);
        cyc();
        chk(ovr_flag === 1'b0, "R10 cleared after stop", int'(ovr_flag), 0);

        // R11: stop and buffer full
        cfg_ext = 1; cfg_len = 6; cfg_scans = 4; cfg_settle = 2; tick_mode = 0;
        idle(2);
        cyc(1);
        idle(5);
        cyc(0, 0, 1);
        stb_seen = 0;
        cyc();
        chk(trig_out === 1'b1 && conv_stb === 1'b0, "R11 stop ends burst", int'(trig_out), 1);
        idle(10);
        chk(stb_seen == 0, "R11 no strobes after stop", stb_seen, 0);
        cyc(1);
        idle(3);
        cyc(0, 0, 0, 1);
        cyc();
        chk(trig_out === 1'b1, "R11 buffer full ends burst", int'(trig_out), 1);
        cyc(1, 0, 1);
        cyc();
        chk(trig_out === 1'b1, "R11 stop beats start", int'(trig_out), 1);

        // R2: start during a burst is ignored
        tick_mode = 2;
        stb_seen = 0;
        cyc(1);
        idle(4);
        cyc(1);
        wait_burst(1000);
        chk(stb_seen == 24, "R2 second start ignored", stb_seen, 24);

        // R6: zero settle arms immediately
        cyc(0, 0, 1, 0, 1);
        cfg_len = 3; cfg_scans = 2; cfg_settle = 0; tick_mode = 0;
        idle(2);
        cyc(1);
        wait_burst(100);
        cyc(0, 1);
        cyc();
        chk(ovr_flag === 1'b0, "R6 zero settle accepts retrigger", int'(ovr_flag), 0);
        chk(trig_out === 1'b0, "R6 zero settle new burst", int'(trig_out), 0);
        wait_burst(100);

        // R12: full list and full scan count
        cyc(0, 0, 1);
        cfg_len = 1024; cfg_scans = 1; cfg_settle = 5;
        idle(2);
        stb_seen = 0;
        cyc(1);
        wait_burst(2000);
        chk(stb_seen == 1024, "R12 full list length", stb_seen, 1024);
        chk(conv_idx === 10'd1023, "R12 top index", int'(conv_idx), 1023);
        cyc(0, 0, 1);
        cfg_len = 1; cfg_scans = 256;
        idle(2);
        stb_seen = 0;
        cyc(1);
        wait_burst(2000);
        chk(stb_seen == 256, "R12 full scan count", stb_seen, 256);
        chk(conv_idx === 10'd0, "R12 single entry index", int'(conv_idx), 0);

        idle(4);
        summary();
        $finish;
    end

endmodule